// File: doc/BRIEF.md
# Asynchronous Schedule Park Arbiter

This block sits beside the walker that traverses the asynchronous list of queue heads. After each finished transaction it decides whether the walker should run another transaction on the same queue head or move on to the next one. When parking is switched on, a high-speed queue head that still has work may be served up to a programmed number of times in a row (one to three) before the walker is forced forward. Queue heads that are not high speed, and every queue head while parking is off, get one transaction per visit.

Two configuration values hold the park settings: an enable bit and a 2-bit run limit. Both are loaded through a single write strobe and are always visible on outputs. A schedule-enable input gates the whole decision. While it is low, finished transactions are ignored, the schedule is reported idle and the run counter is cleared.

Top module: `async_park_arbiter`

## Requirements
- R1: After reset the park-enable output is 1, the park-limit output is 3, and the run counter is 0. A first high-speed queue head with work therefore stays twice and advances on its third transaction.
- R2: While `sched_en` is 0, `sched_active`, `advance` and `stay` are all 0 whatever `xact_done` does. While `sched_en` is 1, `sched_active` is 1.
- R3: With parking on, a limit N in 1..3, a high-speed queue head and `qh_more`=1, `stay` is 1 on the first N-1 consecutive transactions and `advance` is 1 on the Nth.
- R4: A transaction on a queue head with `qh_hs`=0 always yields `advance`.
- R5: With parking off, every transaction yields `advance`.
- R6: A transaction with `qh_more`=0 yields `advance` at once, whatever the count.
- R7: The run counter returns to 0 on every advance, so the next queue head starts a fresh run.
- R8: A limit of 0 with parking on behaves exactly like a limit of 1.
- R9: A cycle with `cfg_wr`=1 loads `cfg_park_en` and `cfg_park_cnt`, and they appear on `park_en` and `park_cnt` after the next clock edge. Without the strobe both outputs hold.
- R10: On each transaction accepted while the schedule is enabled, exactly one of `advance` and `stay` is 1. Without `xact_done` both are 0.
- R11: Dropping `sched_en` clears the run counter. A partly served queue head starts a fresh run when the schedule is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_en | input | 1 | Asynchronous schedule enable |
| cfg_wr | input | 1 | Load strobe for the park settings |
| cfg_park_en | input | 1 | Park enable value to load |
| cfg_park_cnt | input | CNT_W | Park limit value to load |
| xact_done | input | 1 | One transaction on the current queue head finished |
| qh_hs | input | 1 | Current queue head is high speed |
| qh_more | input | 1 | Current queue head has further work |
| park_en | output | 1 | Current park enable |
| park_cnt | output | CNT_W | Current park limit |
| sched_active | output | 1 | Schedule is being processed |
| advance | output | 1 | Move to the next queue head |
| stay | output | 1 | Serve the current queue head again |

## Verification
The bench uses the default `CNT_W` of 2, which matches the 2-bit limit field. This puts every legal limit (1, 2, 3) and the illegal value 0 within reach. It also lets the counter's top value, the case where the counter sits at a limit of 3, be reached in three transactions. The bench mixes high-speed and full-speed queue heads, queue heads that empty early, and limits that are changed between runs, and it toggles the schedule enable in the middle of a run.

// File: rtl/async_park_arbiter.sv
module async_park_arbiter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sched_en,
  input  logic             cfg_wr,
  input  logic             cfg_park_en,
  input  logic [CNT_W-1:0] cfg_park_cnt,
  input  logic             xact_done,
  input  logic             qh_hs,
  input  logic             qh_more,
  output logic             park_en,
  output logic [CNT_W-1:0] park_cnt,
  output logic             sched_active,
  output logic             advance,
  output logic             stay
);
  localparam int          EW       = CNT_W + 1;
  localparam [CNT_W-1:0]  CNT_RST  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_cnt;
  logic [EW-1:0]    limit;
  logic [EW-1:0]    next_run;
  logic             take;

  assign sched_active = sched_en;
  assign take         = sched_en & xact_done;
  assign next_run     = EW'(run_cnt) + EW'(1);
  assign limit        = (!park_en || !qh_hs || park_cnt == '0) ? EW'(1) : EW'(park_cnt);
  assign advance      = take & (!qh_more | (next_run >= limit));
  assign stay         = take & ~advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      park_en  <= 1'b1;
      park_cnt <= CNT_RST;
    end else if (cfg_wr) begin
      park_en  <= cfg_park_en;
      park_cnt <= cfg_park_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sched_en || advance)
      run_cnt <= '0;
    else if (stay)
      run_cnt <= next_run[CNT_W-1:0];
  end
endmodule

// File: rtl/async_park_arbiter_chk.sv
module async_park_arbiter_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sched_en,
  input logic             cfg_wr,
  input logic             cfg_park_en,
  input logic [CNT_W-1:0] cfg_park_cnt,
  input logic             xact_done,
  input logic             qh_hs,
  input logic             qh_more,
  input logic             park_en,
  input logic [CNT_W-1:0] park_cnt,
  input logic             sched_active,
  input logic             advance,
  input logic             stay
);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_en |-> (!advance && !stay && !sched_active));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({advance, stay}) == (sched_en && xact_done ? 1 : 0));
  a_r4_non_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && xact_done && !qh_hs) |-> advance);
  a_r5_park_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && xact_done && !park_en) |-> advance);
  a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && xact_done && !qh_more) |-> advance);
  a_r8_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && xact_done && park_en && park_cnt == '0) |-> advance);
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (park_en == $past(cfg_park_en) && park_cnt == $past(cfg_park_cnt)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && $past(rst_n)) |=> ($stable(park_en) && $stable(park_cnt)));
  a_r7_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && park_cnt != '0 && park_cnt != 2'(1)) |=>
      ((sched_en && xact_done && qh_hs && qh_more && park_en && $stable(park_cnt)) |-> stay));
endmodule

bind async_park_arbiter async_park_arbiter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/async_park_arbiter_test.sv
module async_park_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, sched_en = 1'b0, cfg_wr = 1'b0, cfg_park_en = 1'b0;
  logic [CNT_W-1:0] cfg_park_cnt = '0;
  logic xact_done = 1'b0, qh_hs = 1'b0, qh_more = 1'b0;
  logic park_en, sched_active, advance, stay;
  logic [CNT_W-1:0] park_cnt;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit exp_q[$];
  string tag_q[$];
  int m_cnt = 0;
  bit m_pe = 1'b1;
  int m_pc = 3;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_park_arbiter #(.CNT_W(CNT_W)) uut (.*);

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (rst_n && sched_en && xact_done && exp_q.size() != 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " advance"}, advance, e);
      check({t, " stay"}, stay, !e);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic xact(bit hs, bit more, string tag);
    int lim;
    bit adv;
    step();
    lim = (!m_pe || !hs || m_pc == 0) ? 1 : m_pc;
    adv = !more || (m_cnt + 1 >= lim);
    m_cnt = adv ? 0 : m_cnt + 1;
    exp_q.push_back(adv);
    tag_q.push_back(tag);
    xact_done = 1'b1; qh_hs = hs; qh_more = more;
    step();
    xact_done = 1'b0;
  endtask

  task automatic cfg(bit pe, int pc);
    step();
    cfg_wr = 1'b1; cfg_park_en = pe; cfg_park_cnt = CNT_W'(pc);
    step();
    cfg_wr = 1'b0; cfg_park_en = ~pe; cfg_park_cnt = '0;
    m_pe = pe; m_pc = pc;
    @(negedge clk);
    check("R9 park_en", park_en, pe);
    check("R9 park_cnt", park_cnt, pc);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 park_en reset", park_en, 1);
    check("R1 park_cnt reset", park_cnt, 3);
    check("R2 idle advance", advance, 0);
    check("R2 idle active", sched_active, 0);
    xact_done = 1'b1; qh_hs = 1'b1; qh_more = 1'b1;
    #1 check("R2 done ignored advance", advance, 0);
    check("R2 done ignored stay", stay, 0);
    step(); xact_done = 1'b0;
    sched_en = 1'b1;
    #1 check("R2 active", sched_active, 1);
    cfg_wr = 1'b0; cfg_park_en = 1'b0; cfg_park_cnt = 2'd1;
    step(); step();
    @(negedge clk);
    check("R9 hold park_en", park_en, 1);
    check("R9 hold park_cnt", park_cnt, 3);
    for (int i = 0; i < 3; i++) xact(1, 1, "R1 R3 limit3");
    for (int i = 0; i < 3; i++) xact(1, 1, "R7 fresh run");
    xact(1, 1, "R6 first");
    xact(1, 0, "R6 empty early");
    xact(0, 1, "R4 full speed");
    xact(0, 1, "R4 full speed again");
    cfg(1, 2);
    for (int i = 0; i < 4; i++) xact(1, 1, "R3 limit2");
    cfg(1, 1);
    for (int i = 0; i < 2; i++) xact(1, 1, "R3 limit1");
    cfg(1, 0);
    for (int i = 0; i < 3; i++) xact(1, 1, "R8 zero limit");
    cfg(0, 3);
    for (int i = 0; i < 3; i++) xact(1, 1, "R5 park off");
    cfg(1, 3);
    xact(1, 1, "R11 before drop");
    xact(1, 1, "R11 before drop 2");
    step(); sched_en = 1'b0; m_cnt = 0;
    #1 check("R2 drop active", sched_active, 0);
    step(); sched_en = 1'b1;
    for (int i = 0; i < 3; i++) xact(1, 1, "R11 after reenable");
    #1 check("R10 no done advance", advance, 0);
    check("R10 no done stay", stay, 0);
    repeat (3) step();
    check("scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule